// File: doc/BRIEF.md
# Bit-Field Extract and Insert Unit

This unit is one functional slice of a simple 32-bit processor execute stage. It decodes the current instruction word and recognises two bit-field operations. The extract operation pulls a field out of the source operand and returns it right-aligned, with every bit above the field cleared. The insert operation takes the low bits of the source operand and merges them into the old destination value at a chosen position. All destination bits outside the field keep their old value.

The register file supplies the source operand and the old destination value. The unit returns a registered result, the destination register index, an output valid and an illegal-encoding flag, all one cycle later. Extract encodes the field width directly. Insert instead encodes the index of the field's top bit, so its mask is built from a low and a high bit position.

Top module: `bitfield_unit`

## Requirements
- R1: A valid word whose bits 31:26 are 011001 and bits 15:14 are 01 is an extract. The result is the source shifted right by bits 4:0, masked to the low N bits, where N is bits 10:6. All other result bits are zero and the output valid is set.
- R2: An extract with a width field (bits 10:6) of 0 gives an all-zero result, is legal, and sets the output valid.
- R3: A valid word with bits 31:26 equal to 011001 and bits 15:14 equal to 10 is an insert, where shift = bits 4:0 and top = bits 10:6. When top >= shift, source bits 0 through top−shift replace destination bits shift through top. Every other bit keeps the old destination value, and the illegal flag stays low.
- R4: An insert whose top index (bits 10:6) is below its shift (bits 4:0) sets both the illegal flag and the output valid, and returns the old destination value unchanged.
- R5: A valid word with bits 31:26 equal to 011001 and bits 15:14 equal to 11 sets the illegal flag and leaves the output valid low, so no write takes place.
- R6: With the input valid low, or with a word whose opcode differs or whose bits 15:14 are 00, both the output valid and the illegal flag are low on the next cycle.
- R7: On the cycle after an accepted word, the destination index output equals bits 25:21 of that word. The latency is exactly one cycle.
- R8: A synchronous active-high reset clears the output valid, the illegal flag, the result and the destination index.
- R9: An extract whose width plus shift exceeds 32 sets the illegal flag together with the output valid. Its result holds the source bits from the shift upward, with positions beyond bit 31 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word and operands are present |
| instr | input | 32 | Instruction word |
| src_val | input | 32 | Source operand |
| dst_old | input | 32 | Current value of the destination register |
| res_valid | output | 1 | Registered result is to be written |
| res_illegal | output | 1 | Registered illegal-encoding flag |
| res_data | output | 32 | Registered result |
| res_dst | output | 5 | Registered destination register index |

## Verification
Extract and insert are each run over every one of the 1024 pairs of field value and shift, with a fresh random source and destination for each pair. This sweep separates the width-0 and full-width edges, the overrange extracts and the inverted inserts from the legal cases. The reserved selector 11, the unused selector 00, a foreign opcode and an idle cycle each check that the valid and illegal outputs are kept apart. A reset issued in the middle of the run confirms that all outputs return to their cleared state.

// File: rtl/bitfield_unit.sv
module bitfield_unit #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] src_val,
  input  logic [XLEN-1:0] dst_old,
  output logic            res_valid,
  output logic            res_illegal,
  output logic [XLEN-1:0] res_data,
  output logic [4:0]      res_dst
);
  localparam logic [5:0] OPC = 6'b011001;
  localparam int SW = $clog2(XLEN);

  logic          op_hit, is_ext, is_ins, is_rsv;
  logic [SW-1:0] fld, sh;
  logic [SW:0]   sum, top1;
  logic          ext_over, ins_bad;
  logic [XLEN:0] one, ext_m, hi_m, lo_m;
  logic [XLEN-1:0] ins_m, ext_val, ins_val;

  assign op_hit = in_valid && (instr[31:26] == OPC);
  assign is_ext = op_hit && (instr[15:14] == 2'b01);
  assign is_ins = op_hit && (instr[15:14] == 2'b10);
  assign is_rsv = op_hit && (instr[15:14] == 2'b11);

  assign fld  = instr[6 +: SW];
  assign sh   = instr[0 +: SW];
  assign sum  = {1'b0, fld} + {1'b0, sh};
  assign top1 = {1'b0, fld} + {{SW{1'b0}}, 1'b1};

  assign ext_over = sum > (SW+1)'(XLEN);
  assign ins_bad  = fld < sh;

  assign one   = {{XLEN{1'b0}}, 1'b1};
  assign ext_m = (one << fld) - one;
  assign hi_m  = (one << top1) - one;
  assign lo_m  = (one << sh) - one;
  assign ins_m = hi_m[XLEN-1:0] & ~lo_m[XLEN-1:0];

  assign ext_val = (src_val >> sh) & ext_m[XLEN-1:0];
  assign ins_val = ins_bad ? dst_old
                           : (dst_old & ~ins_m) | ((src_val << sh) & ins_m);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid   <= 1'b0;
      res_illegal <= 1'b0;
      res_data    <= '0;
      res_dst     <= '0;
    end else begin
      res_valid   <= is_ext || is_ins;
      res_illegal <= is_rsv || (is_ext && ext_over) || (is_ins && ins_bad);
      if (is_ext || is_ins) begin
        res_data <= is_ext ? ext_val : ins_val;
        res_dst  <= instr[25:21];
      end
    end
  end
endmodule

// File: rtl/bitfield_unit_chk.sv
module bitfield_unit_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [31:0]     instr,
  input logic [XLEN-1:0] src_val,
  input logic [XLEN-1:0] dst_old,
  input logic            res_valid,
  input logic            res_illegal,
  input logic [XLEN-1:0] res_data,
  input logic [4:0]      res_dst
);
  logic hit, ext, ins, rsv;
  assign hit = in_valid && instr[31:26] == 6'b011001;
  assign ext = hit && instr[15:14] == 2'b01;
  assign ins = hit && instr[15:14] == 2'b10;
  assign rsv = hit && instr[15:14] == 2'b11;

  p_ext_valid_r1: assert property (@(posedge clk) disable iff (rst)
    ext |=> res_valid);

  p_zero_width_r2: assert property (@(posedge clk) disable iff (rst)
    ext && instr[10:6] == 5'd0 |=> res_data == '0 && !res_illegal);

  p_low_kept_r3: assert property (@(posedge clk) disable iff (rst)
    ins |=> ((res_data ^ $past(dst_old)) & ((XLEN'(1) << $past(instr[4:0])) - XLEN'(1))) == '0);

  p_bad_insert_r4: assert property (@(posedge clk) disable iff (rst)
    ins && instr[10:6] < instr[4:0] |=> res_illegal && res_valid && res_data == $past(dst_old));

  p_reserved_r5: assert property (@(posedge clk) disable iff (rst)
    rsv |=> res_illegal && !res_valid);

  p_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !res_valid && !res_illegal);

  p_dst_index_r7: assert property (@(posedge clk) disable iff (rst)
    ext || ins |=> res_dst == $past(instr[25:21]));

  p_reset_r8: assert property (@(posedge clk)
    rst |=> !res_valid && !res_illegal);

  p_overrange_r9: assert property (@(posedge clk) disable iff (rst)
    ext && ({1'b0, instr[10:6]} + {1'b0, instr[4:0]}) > 6'd32 |=> res_illegal && res_valid);
endmodule

bind bitfield_unit bitfield_unit_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/bitfield_unit_bench.sv
module bitfield_unit_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] instr, src_val, dst_old;
  logic        res_valid, res_illegal;
  logic [31:0] res_data;
  logic [4:0]  res_dst;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bitfield_unit u_bitfield_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
    .src_val(src_val), .dst_old(dst_old), .res_valid(res_valid),
    .res_illegal(res_illegal), .res_data(res_data), .res_dst(res_dst)
  );

  function automatic logic [31:0] mk(input logic [5:0] opc, input logic [1:0] sel,
                                     input int rd, input int ra, input int f, input int s);
    return {opc, 5'(rd), 5'(ra), sel, 3'b000, 5'(f), 1'b0, 5'(s)};
  endfunction

  task automatic check(input string tag, input logic [37:0] act, input logic [37:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference: drive one word, check registered outputs one cycle later.
  task automatic step(input logic v, input logic [31:0] w, input logic [31:0] s, input logic [31:0] d);
    logic ev, ei;
    logic [31:0] ed;
    string tag;
    int f = int'(w[10:6]);
    int sh = int'(w[4:0]);
    ev = 0; ei = 0; ed = 'x; tag = "R6";
    if (v && w[31:26] == 6'b011001) begin
      case (w[15:14])
        2'b01: begin
          ev = 1; ed = '0;
          for (int i = 0; i < 32; i++)
            if (i < f && i + sh < 32) ed[i] = s[i + sh];
          ei = (f + sh > 32);
          tag = ei ? "R9" : (f == 0 ? "R2" : "R1");
        end
        2'b10: begin
          ev = 1; ed = d;
          if (f < sh) begin ei = 1; tag = "R4"; end
          else begin
            for (int i = sh; i <= f; i++) ed[i] = s[i - sh];
            tag = "R3";
          end
        end
        2'b11: begin ei = 1; tag = "R5"; end
        default: ;
      endcase
    end
    @(negedge clk);
    in_valid = v; instr = w; src_val = s; dst_old = d;
    @(negedge clk);
    check({tag, " valid/illegal"}, {36'd0, res_valid, res_illegal}, {36'd0, ev, ei});
    if (ev) begin
      check(tag, {6'd0, res_data}, {6'd0, ed});
      check("R7 dst index", {33'd0, res_dst}, {33'd0, w[25:21]});
    end
    in_valid = 0;
  endtask

  initial begin
    #1500000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1; in_valid = 0; instr = '0; src_val = '0; dst_old = '0;
    repeat (3) @(negedge clk);
    check("R8 reset state", {res_valid, res_illegal, res_data, res_dst},
          {2'b00, 32'd0, 5'd0});
    rst = 0;

    step(1, mk(6'b011001, 2'b01, 3, 4, 8, 4), 32'hDEADBEEF, 32'h0);
    step(1, mk(6'b011001, 2'b10, 7, 1, 15, 8), 32'h000000A5, 32'hFFFFFFFF);
    step(1, mk(6'b011001, 2'b01, 1, 2, 31, 1), 32'hFFFFFFFF, 32'h0);
    step(1, mk(6'b011001, 2'b10, 2, 2, 31, 0), 32'h12345678, 32'h9ABCDEF0);

    for (int f = 0; f < 32; f++)
      for (int s = 0; s < 32; s++)
        step(1, mk(6'b011001, 2'b01, (f + s) % 32, f, f, s), $urandom, $urandom);
    for (int f = 0; f < 32; f++)
      for (int s = 0; s < 32; s++)
        step(1, mk(6'b011001, 2'b10, (f * 3 + s) % 32, s, f, s), $urandom, $urandom);

    step(1, mk(6'b011001, 2'b11, 5, 6, 10, 2), $urandom, $urandom);
    step(1, mk(6'b011001, 2'b00, 5, 6, 10, 2), $urandom, $urandom);
    step(1, mk(6'b011000, 2'b01, 5, 6, 10, 2), $urandom, $urandom);
    step(0, mk(6'b011001, 2'b01, 5, 6, 10, 2), $urandom, $urandom);
    step(0, mk(6'b011001, 2'b11, 5, 6, 10, 2), $urandom, $urandom);

    step(1, mk(6'b011001, 2'b10, 9, 3, 20, 4), $urandom, $urandom);
    @(negedge clk);
    in_valid = 1; instr = mk(6'b011001, 2'b01, 4, 4, 4, 4); rst = 1;
    @(negedge clk);
    check("R8 mid-run reset", {res_valid, res_illegal, res_data, res_dst},
          {2'b00, 32'd0, 5'd0});
    rst = 0; in_valid = 0;

    for (int k = 0; k < 200; k++)
      step(1, mk(6'b011001, 2'(1 + $urandom % 3), $urandom % 32, $urandom % 32,
                 $urandom % 32, $urandom % 32), $urandom, $urandom);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule